// File: doc/BRIEF.md
# Freeze-Gated Converter Control Register File

This block holds the control settings of a multichannel audio converter. A host reaches it through a plain write port (enable, address, data) and a read port that returns data one clock after the request. One format register sets the serial formats of the converter's DAC port, ADC port and auxiliary port. Alongside them sits a hold bit. The remaining registers carry per-channel mute, per-channel polarity invert, and one volume byte per DAC channel and per ADC channel.

Each mute, invert and volume register is kept as two copies. The staged copy takes every host write and is what the read port returns. The live copy drives the datapath outputs. While the hold bit is clear, the live copies follow the staged copies. While it is set, the live copies stay still, so the host can prepare any number of changes. When the host clears the hold bit, every prepared change reaches the outputs on the same clock edge. The format register itself is never held back.

Top module: `frz_ctl_regs`

## Requirements
- R1: A synchronous active-high reset sets the format register to 0x30 and every staged and live mute, invert and volume value to 0x00. The format register reads 0x30 after reset, and the DAC format output is 3'b110.
- R2: The format register at address 0x04 has this layout: bit 7 is the hold bit, bit 6 is the auxiliary format (0 = left-justified, 1 = I2S), bits 5:3 are the DAC format and bits 2:0 are the ADC format. A write to it shows on freeze_o, aux_i2s_o, dac_fmt_o and adc_fmt_o after the write edge, whatever the hold bit's value.
- R3: While the hold bit is 1, writes to mute, invert and volume registers change only the staged copies. Every live output keeps its value.
- R4: A read of a mute, invert or volume register returns its staged value, including values written while the hold bit is 1. rd_data holds the result from the edge that samples rd_en until the next read.
- R5: On the first clock edge after the edge that writes the hold bit to 0, all live copies load their staged values together. Before that edge, no live output changes.
- R6: While the hold bit is 0, a write to a staged register reaches its live output on the clock edge after the write edge.
- R7: The address map is: DAC mute 0x05, ADC mute 0x06, DAC invert 0x07, ADC invert 0x08, DAC volume k at 0x10+k (k = 0..7), ADC volume k at 0x18+k (k = 0..5). Mute and invert bit c controls channel c. Volume k drives byte k of the matching volume output, and byte 0 is the least significant.
- R8: Mute and invert registers store one bit per channel, 8 for DAC and 6 for ADC. The other written bits are dropped, and they read as 0.
- R9: An address outside the map reads as 0x00, and a write to it changes no output and no readable register.
- R10: A read and a write to the same address on the same edge return the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data |
| freeze_o | output | 1 | Hold bit currently in force |
| aux_i2s_o | output | 1 | Auxiliary port format, 1 = I2S |
| dac_fmt_o | output | 3 | DAC port format code |
| adc_fmt_o | output | 3 | ADC port format code |
| dac_mute_o | output | N_DAC | Live DAC channel mutes |
| adc_mute_o | output | N_ADC | Live ADC channel mutes |
| dac_inv_o | output | N_DAC | Live DAC channel inverts |
| adc_inv_o | output | N_ADC | Live ADC channel inverts |
| dac_vol_o | output | N_DAC*DATA_W | Live DAC volumes, one byte per channel |
| adc_vol_o | output | N_ADC*DATA_W | Live ADC volumes, one byte per channel |

## Verification
The assertions check four things on every cycle: the live values stay still while the hold bit is set, the live values match the staged values one edge after the hold bit falls, a format write reaches the outputs right away, and unmapped reads return zero. The reset values are checked on the edge after reset. Only the bench's scenarios can show the rest. These are the address-to-output mapping, the dropped upper bits of the per-channel registers, the fact that writes to unused addresses change nothing, and the exact cycle at which a release or an unheld write shows up. The bench runs a full sweep of all addresses and format values against an independent model.

// File: rtl/frz_ctl_pkg.sv
package frz_ctl_pkg;

  typedef struct packed {
    logic       hold;
    logic       aux_i2s;
    logic [2:0] dac_fmt;
    logic [2:0] adc_fmt;
  } fmt_reg_t;

  localparam fmt_reg_t FMT_RST = '{hold: 1'b0, aux_i2s: 1'b0,
                                   dac_fmt: 3'b110, adc_fmt: 3'b000};

endpackage

// File: rtl/frz_fmt_reg.sv
module frz_fmt_reg
  import frz_ctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_en,
  input  logic [7:0] wr_data,
  output fmt_reg_t fmt_o
);

  always_ff @(posedge clk) begin
    if (rst)        fmt_o <= FMT_RST;
    else if (wr_en) fmt_o <= fmt_reg_t'(wr_data);
  end

  // R2: the format register is never held back by the hold bit
  assert_fmt_now_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (fmt_o == fmt_reg_t'($past(wr_data))));

endmodule

// File: rtl/frz_cell.sv
module frz_cell #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         load_en,
  output logic [W-1:0] shadow_o,
  output logic [W-1:0] active_o
);

  always_ff @(posedge clk) begin
    if (rst)        shadow_o <= '0;
    else if (wr_en) shadow_o <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)          active_o <= '0;
    else if (load_en) active_o <= shadow_o;
  end

  // R3: no live change while the load is held off
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(active_o));

endmodule

// File: rtl/frz_ctl_regs.sv
module frz_ctl_regs
  import frz_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned N_DAC      = 8,
  parameter int unsigned N_ADC      = 6,
  parameter int unsigned FMT_ADDR   = 4,
  parameter int unsigned DMUTE_ADDR = 5,
  parameter int unsigned AMUTE_ADDR = 6,
  parameter int unsigned DINV_ADDR  = 7,
  parameter int unsigned AINV_ADDR  = 8,
  parameter int unsigned DVOL_BASE  = 16,
  parameter int unsigned AVOL_BASE  = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    freeze_o,
  output logic                    aux_i2s_o,
  output logic [2:0]              dac_fmt_o,
  output logic [2:0]              adc_fmt_o,
  output logic [N_DAC-1:0]        dac_mute_o,
  output logic [N_ADC-1:0]        adc_mute_o,
  output logic [N_DAC-1:0]        dac_inv_o,
  output logic [N_ADC-1:0]        adc_inv_o,
  output logic [N_DAC*DATA_W-1:0] dac_vol_o,
  output logic [N_ADC*DATA_W-1:0] adc_vol_o
);

  localparam int unsigned NREG    = 4 + N_DAC + N_ADC;
  localparam int unsigned DVOL_IX = 4;
  localparam int unsigned AVOL_IX = 4 + N_DAC;

  function automatic int unsigned width_of(int unsigned i);
    if (i == 0 || i == 2) return N_DAC;
    if (i == 1 || i == 3) return N_ADC;
    return DATA_W;
  endfunction

  function automatic logic [ADDR_W-1:0] addr_of(int unsigned i);
    int unsigned a;
    case (i)
      0:       a = DMUTE_ADDR;
      1:       a = AMUTE_ADDR;
      2:       a = DINV_ADDR;
      3:       a = AINV_ADDR;
      default: a = (i < AVOL_IX) ? DVOL_BASE + i - DVOL_IX
                                 : AVOL_BASE + i - AVOL_IX;
    endcase
    return ADDR_W'(a);
  endfunction

  fmt_reg_t fmt_q;
  logic     fmt_we;

  assign fmt_we = wr_en && (wr_addr == ADDR_W'(FMT_ADDR));

  frz_fmt_reg u_fmt (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (fmt_we),
    .wr_data (wr_data[7:0]),
    .fmt_o   (fmt_q)
  );

  assign freeze_o  = fmt_q.hold;
  assign aux_i2s_o = fmt_q.aux_i2s;
  assign dac_fmt_o = fmt_q.dac_fmt;
  assign adc_fmt_o = fmt_q.adc_fmt;

  logic [DATA_W-1:0]      shd_ext [NREG];
  logic [NREG*DATA_W-1:0] shd_bus;
  logic [NREG*DATA_W-1:0] act_bus;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam int unsigned     W = width_of(i);
    localparam logic [ADDR_W-1:0] A = addr_of(i);
    logic [W-1:0] shd;
    logic [W-1:0] act;

    frz_cell #(.W(W)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en && (wr_addr == A)),
      .wr_data  (wr_data[W-1:0]),
      .load_en  (!fmt_q.hold),
      .shadow_o (shd),
      .active_o (act)
    );

    assign shd_ext[i]                    = DATA_W'(shd);
    assign shd_bus[i*DATA_W +: DATA_W]   = DATA_W'(shd);
    assign act_bus[i*DATA_W +: DATA_W]   = DATA_W'(act);
  end

  assign dac_mute_o = g_reg[0].act;
  assign adc_mute_o = g_reg[1].act;
  assign dac_inv_o  = g_reg[2].act;
  assign adc_inv_o  = g_reg[3].act;

  for (genvar k = 0; k < N_DAC; k++) begin : g_dvol
    assign dac_vol_o[k*DATA_W +: DATA_W] = g_reg[DVOL_IX + k].act;
  end

  for (genvar k = 0; k < N_ADC; k++) begin : g_avol
    assign adc_vol_o[k*DATA_W +: DATA_W] = g_reg[AVOL_IX + k].act;
  end

  // Read path: select by address, register the result
  logic [DATA_W-1:0] rd_next;
  logic              rd_hit;

  always_comb begin
    rd_next = '0;
    rd_hit  = 1'b0;
    if (rd_addr == ADDR_W'(FMT_ADDR)) begin
      rd_next = DATA_W'(fmt_q);
      rd_hit  = 1'b1;
    end
    for (int unsigned i = 0; i < NREG; i++) begin
      if (rd_addr == addr_of(i)) begin
        rd_next = shd_ext[i];
        rd_hit  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  // R1: reset values
  assert_reset_vals_R1: assert property (@(posedge clk)
    rst |=> (dac_fmt_o == 3'b110 && adc_fmt_o == 3'b000 && !freeze_o &&
             !aux_i2s_o && act_bus == '0));

  // R3: live bus frozen while hold is set
  assert_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    freeze_o |=> $stable(act_bus));

  // R5: one edge after release, every live copy equals its staged copy
  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(freeze_o) |=> (act_bus == $past(shd_bus)));

  // R9: unmapped reads return zero
  assert_unmapped_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_hit) |=> (rd_data == '0));

endmodule

// File: tb/frz_ctl_regs_tb.sv
module frz_ctl_regs_tb_top;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int N_DAC  = 8;
  localparam int N_ADC  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic freeze_o, aux_i2s_o;
  logic [2:0] dac_fmt_o, adc_fmt_o;
  logic [N_DAC-1:0] dac_mute_o, dac_inv_o;
  logic [N_ADC-1:0] adc_mute_o, adc_inv_o;
  logic [N_DAC*DATA_W-1:0] dac_vol_o;
  logic [N_ADC*DATA_W-1:0] adc_vol_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m_shd [256];
  logic [7:0] m_act [256];
  logic [7:0] m_rd;

  always #(CLK_P/2) clk = ~clk;

  frz_ctl_regs dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .freeze_o(freeze_o), .aux_i2s_o(aux_i2s_o), .dac_fmt_o(dac_fmt_o),
    .adc_fmt_o(adc_fmt_o), .dac_mute_o(dac_mute_o), .adc_mute_o(adc_mute_o),
    .dac_inv_o(dac_inv_o), .adc_inv_o(adc_inv_o),
    .dac_vol_o(dac_vol_o), .adc_vol_o(adc_vol_o)
  );

  // Storage mask per address, taken from R7 and R8; zero means unmapped (R9)
  function automatic logic [7:0] mask_of(int a);
    if (a == 4) return 8'hFF;
    if (a == 5 || a == 7) return 8'((1 << N_DAC) - 1);
    if (a == 6 || a == 8) return 8'((1 << N_ADC) - 1);
    if (a >= 16 && a < 16 + N_DAC) return 8'hFF;
    if (a >= 24 && a < 24 + N_ADC) return 8'hFF;
    return 8'h00;
  endfunction

  task automatic model_init();
    for (int a = 0; a < 256; a++) begin
      m_shd[a] = 8'h00;
      m_act[a] = 8'h00;
    end
    m_shd[4] = 8'h30;
    m_act[4] = 8'h30;
    m_rd = 8'h00;
  endtask

  // One clock: update the model on the rising edge, return at the falling edge
  task automatic cyc();
    @(posedge clk);
    if (rst) model_init();
    else begin
      if (rd_en) m_rd = m_shd[rd_addr];
      if (!m_shd[4][7]) begin
        for (int a = 0; a < 256; a++) if (a != 4) m_act[a] = m_shd[a];
      end
      if (wr_en) m_shd[wr_addr] = wr_data & mask_of(int'(wr_addr));
    end
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic chk_out(string req);
    logic [63:0] dv, av;
    dv = '0;
    av = '0;
    for (int k = 0; k < N_DAC; k++) dv[k*8 +: 8] = m_act[16+k];
    for (int k = 0; k < N_ADC; k++) av[k*8 +: 8] = m_act[24+k];
    chk(req, "freeze_o",  64'(freeze_o),  64'(m_shd[4][7]));
    chk(req, "aux_i2s_o", 64'(aux_i2s_o), 64'(m_shd[4][6]));
    chk(req, "dac_fmt_o", 64'(dac_fmt_o), 64'(m_shd[4][5:3]));
    chk(req, "adc_fmt_o", 64'(adc_fmt_o), 64'(m_shd[4][2:0]));
    chk(req, "dac_mute_o", 64'(dac_mute_o), 64'(m_act[5][N_DAC-1:0]));
    chk(req, "adc_mute_o", 64'(adc_mute_o), 64'(m_act[6][N_ADC-1:0]));
    chk(req, "dac_inv_o",  64'(dac_inv_o),  64'(m_act[7][N_DAC-1:0]));
    chk(req, "adc_inv_o",  64'(adc_inv_o),  64'(m_act[8][N_ADC-1:0]));
    chk(req, "dac_vol_o",  64'(dac_vol_o),  dv);
    chk(req, "adc_vol_o",  64'(adc_vol_o),  av);
  endtask

  task automatic wr(int a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(int a, string req);
    rd_en = 1'b1; rd_addr = 8'(a);
    cyc();
    rd_en = 1'b0;
    chk(req, $sformatf("rd_data @%0h", a), 64'(rd_data), 64'(m_rd));
  endtask

  function automatic string rd_req(int a, bit frozen);
    logic [7:0] m;
    m = mask_of(a);
    if (m == 8'h00) return "R9";
    if (a == 4) return "R2";
    if (m != 8'hFF) return "R8";
    return frozen ? "R4" : "R7";
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_init();
    @(negedge clk);
    rst = 1'b1;
    cyc(); cyc(); cyc();
    rst = 1'b0;
    chk_out("R1");
    for (int a = 0; a < 256; a++) rd_chk(a, (mask_of(a) == 0) ? "R9" : "R1");

    // Hold on, stage writes to every address but the format register (R3)
    wr(4, 8'hB0);
    chk_out("R2");
    for (int a = 0; a < 256; a++) begin
      if (a != 4) wr(a, 8'((a * 37 + 11) & 8'hFF));
      if (a % 64 == 63) chk_out("R3");
    end
    cyc(); cyc();
    chk_out("R3");
    for (int a = 0; a < 256; a++) rd_chk(a, rd_req(a, 1'b1));

    // Release: nothing at the write edge, everything on the next edge (R5)
    wr(4, 8'h70);
    chk_out("R5");
    cyc();
    chk_out("R5 R7");

    // Unheld write lands one edge after the write edge (R6)
    wr(17, 8'h5A);
    chk_out("R6");
    cyc();
    chk_out("R6");

    // Same-address read and write (R10)
    wr_en = 1'b1; wr_addr = 8'd17; wr_data = 8'hC3;
    rd_en = 1'b1; rd_addr = 8'd17;
    cyc();
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R10", "rd_data same-edge", 64'(rd_data), 64'h5A);
    rd_chk(17, "R10");

    // Full sweep of the format register, held or not (R2)
    for (int v = 0; v < 256; v++) begin
      wr(4, 8'(v));
      chk_out("R2");
      if (v % 32 == 0) wr(24 + (v / 32) % N_ADC, 8'(v + 3));
      chk_out("R2");
    end
    wr(4, 8'h30);
    cyc();
    chk_out("R5");

    // Second staging round with a long hold (R3, R5)
    wr(4, 8'hB0);
    wr(5, 8'hA5);
    wr(8, 8'hFF);
    wr(23, 8'h81);
    wr(200, 8'h77);
    for (int i = 0; i < 5; i++) begin
      cyc();
      chk_out("R3");
    end
    wr(4, 8'h30);
    chk_out("R5");
    cyc();
    chk_out("R5");
    rd_chk(8, "R8");
    rd_chk(200, "R9");

    // Reset in mid-run restores defaults (R1)
    rst = 1'b1;
    cyc();
    rst = 1'b0;
    chk_out("R1");
    rd_chk(4, "R1");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule